// File: doc/BRIEF.md
# Serial Command Bitstream Output Sequencer

This block listens to a serial bitstream that arrives at one bit per clock, for example the data that a serial memory streams out after a read. A qualifying strobe marks each bit that counts. While the stream holds zeros, the block does nothing. A one bit opens a short command frame. The frame carries a value bit and an output address. When the frame is complete, the block writes the value into one bit of an eight-line output register. Each bit of that register can be set or cleared on its own.

If a memory image holds the right frames at the right positions, replaying it produces repetitive control waveforms with no counters, such as horizontal and vertical sync. The number of idle bits between frames sets the time between edges.

The framer is a state machine with two states. `SEQ_HUNT` waits for a start bit. `SEQ_PAYLOAD` collects the payload bits. There are two transitions:

- **hunt-to-payload** fires on a valid one in `SEQ_HUNT`.
- **payload-to-hunt** fires on the valid bit that completes the payload.

Completing the payload issues a command strobe. The output register takes that strobe on the following edge.

Top module: `sbs_cmd_sequencer`

## Requirements
- R1: Synchronous reset drives all eight outputs to 0 and puts the framer in `SEQ_HUNT`. A frame that was partly received when reset arrived is discarded.
- R2: Valid zero bits received in `SEQ_HUNT` leave every output unchanged, however long the run.
- R3: A valid 1 seen in `SEQ_HUNT` is a start bit. The next four valid bits are, in order: the value, then address bit 2, address bit 1, address bit 0. A frame whose value is 1 sets the output at that address.
- R4: A frame whose value is 0 clears the addressed output.
- R5: A frame changes no output other than the addressed one.
- R6: Let E be the rising edge that samples the last payload bit. The addressed output changes on the second rising edge after E, counting E itself as the first. Outputs change at no other time.
- R7: The valid bit that follows the last payload bit is examined as a possible start bit. Frames therefore run back to back with no idle gap.
- R8: A bit presented while `bit_valid` is 0 is ignored. It does not advance a partly received frame, and a 1 presented that way does not start a frame.
- R9: Repeating a fixed sequence of frames and idle bits makes periodic waveforms on the chosen outputs. For example, a line pulse can appear on output 0 and a frame pulse on output 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when `bit_in` carries a stream bit in this cycle |
| bit_in | input | 1 | Serial stream bit |
| ctl_out | output | NUM_OUTS (8) | Latched control lines, each addressed by a frame |

## Verification
The checker assumes two things about the inputs:

- Reset is held for at least one rising edge before any property is enabled.
- After that edge, `bit_valid` and `bit_in` carry known values on every edge.

With those assumptions, the checker's own frame tracker can predict when a command strobe is due. The bench meets them by holding reset for several edges. It drives both inputs to defined levels on falling edges only. Its invalid cycles always put a 1 on `bit_in`, so an ignored bit is never a harmless zero.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Framer states: waiting for a start bit, or collecting payload bits.
    typedef enum logic [0:0] {
        SEQ_HUNT    = 1'b0,
        SEQ_PAYLOAD = 1'b1
    } seq_state_e;

    // Payload width: one value bit plus the address bits.
    function automatic int payload_width(input int addr_w);
        return addr_w + 1;
    endfunction

endpackage

// File: rtl/sbs_framer.sv
module sbs_framer
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              cmd_stb,
    output logic              cmd_val,
    output logic [ADDR_W-1:0] cmd_addr
);

    localparam int PAY_W = payload_width(ADDR_W);
    localparam int CNT_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAY_W - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [PAY_W-1:0]  shift_q;
    logic [PAY_W-1:0]  shift_next;
    logic              take_start;
    logic              take_last;
    logic              stb_q;
    logic              val_q;
    logic [ADDR_W-1:0] addr_q;

    // The value bit arrives first, so it ends up in the MSB after the last shift.
    assign shift_next = {shift_q[PAY_W-2:0], bit_in};
    assign take_start = (state_q == SEQ_HUNT) && bit_valid && bit_in;
    assign take_last  = (state_q == SEQ_PAYLOAD) && bit_valid && (cnt_q == LAST_IDX);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HUNT: begin
                if (take_start) state_d = SEQ_PAYLOAD;
            end
            SEQ_PAYLOAD: begin
                if (take_last) state_d = SEQ_HUNT;
            end
            default: state_d = SEQ_HUNT;
        endcase
    end

    // Payload collection and command outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shift_q <= '0;
            stb_q   <= 1'b0;
            val_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            stb_q <= take_last;
            unique case (state_q)
                SEQ_HUNT: begin
                    cnt_q <= '0;
                end
                SEQ_PAYLOAD: begin
                    if (bit_valid) begin
                        shift_q <= shift_next;
                        cnt_q   <= take_last ? '0 : cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
            if (take_last) begin
                val_q  <= shift_next[PAY_W-1];
                addr_q <= shift_next[ADDR_W-1:0];
            end
        end
    end

    assign cmd_stb  = stb_q;
    assign cmd_val  = val_q;
    assign cmd_addr = addr_q;

endmodule

// File: rtl/sbs_decoder.sv
module sbs_decoder #(
    parameter int NUM_OUTS = 8,
    parameter int ADDR_W   = 3
) (
    input  logic                cmd_stb,
    input  logic                cmd_val,
    input  logic [ADDR_W-1:0]   cmd_addr,
    output logic [NUM_OUTS-1:0] wr_en,
    output logic                wr_val
);

    // One write enable per output line.
    for (genvar gi = 0; gi < NUM_OUTS; gi++) begin : g_sel
        assign wr_en[gi] = cmd_stb && (cmd_addr == ADDR_W'(gi));
    end

    assign wr_val = cmd_val;

endmodule

// File: rtl/sbs_outreg.sv
module sbs_outreg #(
    parameter int NUM_OUTS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_OUTS-1:0] wr_en,
    input  logic                wr_val,
    output logic [NUM_OUTS-1:0] q
);

    // One flop per line; a line reloads only when its own enable is high.
    for (genvar gi = 0; gi < NUM_OUTS; gi++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[gi] <= 1'b0;
            end else if (wr_en[gi]) begin
                q[gi] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/sbs_cmd_sequencer.sv
module sbs_cmd_sequencer #(
    parameter int NUM_OUTS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_valid,
    input  logic                bit_in,
    output logic [NUM_OUTS-1:0] ctl_out
);

    localparam int ADDR_W = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1;

    logic                cmd_stb;
    logic                cmd_val;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [NUM_OUTS-1:0] wr_en;
    logic                wr_val;

    sbs_framer #(.ADDR_W(ADDR_W)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .cmd_stb  (cmd_stb),
        .cmd_val  (cmd_val),
        .cmd_addr (cmd_addr)
    );

    sbs_decoder #(.NUM_OUTS(NUM_OUTS), .ADDR_W(ADDR_W)) u_decoder (
        .cmd_stb (cmd_stb),
        .cmd_val (cmd_val),
        .cmd_addr(cmd_addr),
        .wr_en   (wr_en),
        .wr_val  (wr_val)
    );

    sbs_outreg #(.NUM_OUTS(NUM_OUTS)) u_outreg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wr_val(wr_val),
        .q     (ctl_out)
    );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int NUM_OUTS = 8,
    parameter int ADDR_W   = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                bit_valid,
    input logic                bit_in,
    input logic [NUM_OUTS-1:0] ctl_out
);

    localparam int PAY_W = ADDR_W + 1;

    // Independent frame tracker: pos 0 = hunting, 1..PAY_W = bits taken.
    int                pos_q;
    logic [PAY_W-1:0]  sh_q;
    logic              fire_q;
    logic              val_q;
    logic [ADDR_W-1:0] addr_q;
    logic              armed_q = 1'b0;
    logic              fire;
    logic [PAY_W-1:0]  sh_next;

    assign fire    = bit_valid && (pos_q == PAY_W);
    assign sh_next = {sh_q[PAY_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= 0;
            sh_q    <= '0;
            fire_q  <= 1'b0;
            val_q   <= 1'b0;
            addr_q  <= '0;
            armed_q <= 1'b1;
        end else begin
            fire_q <= fire;
            if (fire) begin
                val_q  <= sh_next[PAY_W-1];
                addr_q <= sh_next[ADDR_W-1:0];
            end
            if (bit_valid) begin
                if (pos_q == 0) begin
                    if (bit_in) pos_q <= 1;
                end else begin
                    sh_q  <= sh_next;
                    pos_q <= (pos_q == PAY_W) ? 0 : pos_q + 1;
                end
            end
        end
    end

    // R1: reset clears every line
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ctl_out == '0));

    // R3/R4: the captured value lands on the addressed line
    p_value_applied_r3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && fire_q && (int'(addr_q) < NUM_OUTS)) |=> (ctl_out[addr_q] == val_q));

    // R5: at most one line moves per edge
    p_single_change_r5: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> ($countones(ctl_out ^ $past(ctl_out)) <= 1));

    // R6: lines hold unless a command is due
    p_change_needs_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !fire_q) |=> $stable(ctl_out));

endmodule

bind sbs_cmd_sequencer sbs_checker #(.NUM_OUTS(NUM_OUTS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_valid(bit_valid),
    .bit_in   (bit_in),
    .ctl_out  (ctl_out)
);

// File: tb/tb_sbs_cmd_sequencer.sv
module tb_sbs_cmd_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_OUTS   = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bit_valid = 1'b0;
    logic                bit_in = 1'b0;
    logic [NUM_OUTS-1:0] ctl_out;

    int                  checks = 0;
    int                  failures = 0;
    logic [NUM_OUTS-1:0] exp_q = '0;
    bit                  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbs_cmd_sequencer #(.NUM_OUTS(NUM_OUTS)) dut (
        .clk      (clk),
        .rst      (rst),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .ctl_out  (ctl_out)
    );

    task automatic check(input string req, input logic [NUM_OUTS-1:0] exp);
        checks++;
        if (ctl_out !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, ctl_out, exp, $time);
        end
    endtask

    // Drive one cycle on the falling edge.
    task automatic drive(input bit v, input bit b);
        @(negedge clk);
        bit_valid = v;
        bit_in    = b;
    endtask

    // Frame bits: start, value, addr[2], addr[1], addr[0]; gap invalid cycles (bit_in=1) between bits.
    task automatic send_cmd(input bit val, input int addr, input int gap);
        logic [4:0] bits;
        bits = {1'b1, val, addr[2], addr[1], addr[0]};
        for (int i = 4; i >= 0; i--) begin
            drive(1'b1, bits[i]);
            if (i != 0) begin
                for (int g = 0; g < gap; g++) drive(1'b0, 1'b1);
            end
        end
    endtask

    // Send one frame, confirm R6 timing, then confirm the new vector.
    task automatic apply_and_check(input bit val, input int addr, input int gap, input string req);
        send_cmd(val, addr, gap);
        drive(1'b1, 1'b0);
        check("R6 early", exp_q);
        exp_q[addr] = val;
        drive(1'b1, 1'b0);
        check(req, exp_q);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b0;
        bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_q = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset", '0);

        // R2: long runs of valid zeros
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, 1'b0);
            if (i % 8 == 7) check("R2 idle zeros", exp_q);
        end

        // R3/R5: set each line in turn
        for (int a = 0; a < NUM_OUTS; a++) apply_and_check(1'b1, a, 0, "R3 set");
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0);
        check("R2 idle zeros hold ones", exp_q);

        // R4/R5: clear in reverse order
        for (int a = NUM_OUTS - 1; a >= 0; a--) apply_and_check(1'b0, a, 0, "R4 clear");

        // R5: alternating pattern across all addresses
        for (int a = 0; a < NUM_OUTS; a++) apply_and_check(a[0], a, 0, "R5 only addressed");
        for (int a = 0; a < NUM_OUTS; a++) apply_and_check(~a[0], a, 0, "R5 only addressed");

        // R8: invalid cycles inside frames, with gaps of 1..3
        for (int g = 1; g <= 3; g++) begin
            for (int a = 0; a < NUM_OUTS; a++) apply_and_check(((a + g) % 2) == 1, a, g, "R8 gaps");
        end
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0);
        check("R8 invalid one no start", exp_q);

        // R7: back-to-back frames. A = set line 2, B = set line 6 (bits 1,1,1,1,0)
        apply_and_check(1'b0, 2, 0, "R7 prep");
        apply_and_check(1'b0, 6, 0, "R7 prep");
        send_cmd(1'b1, 2, 0);
        drive(1'b1, 1'b1);
        check("R6 early b2b", exp_q);
        drive(1'b1, 1'b1);
        exp_q[2] = 1'b1;
        check("R7 first applied", exp_q);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        check("R6 early second", exp_q);
        drive(1'b1, 1'b0);
        exp_q[6] = 1'b1;
        check("R7 second applied", exp_q);

        // R9: periodic sync, line pulse on 0 and frame pulse on 1
        do_reset();
        for (int f = 0; f < 3; f++) begin
            for (int ln = 0; ln < 4; ln++) begin
                if (ln == 0) apply_and_check(1'b1, 1, 0, "R9 frame start");
                apply_and_check(1'b1, 0, 0, "R9 line start");
                for (int i = 0; i < 4; i++) drive(1'b1, 1'b0);
                apply_and_check(1'b0, 0, 0, "R9 line end");
                if (ln == 1) apply_and_check(1'b0, 1, 0, "R9 frame end");
            end
        end

        // R1: reset mid-frame discards the partial frame
        apply_and_check(1'b1, 3, 0, "R1 prep");
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        do_reset();
        drive(1'b1, 1'b0);
        check("R1 reset midframe", '0);
        apply_and_check(1'b1, 5, 0, "R1 framer idle after reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule